// File: doc/BRIEF.md
# Loadable Microsecond Timestamp Counter

This block keeps a 64-bit count of elapsed microseconds. Each pulse on a one-microsecond tick input adds one to the count. Software can also jump the count to a new value. It does this through a small register bus made of a write strobe, a read strobe, a register index and 32-bit data words.

The new value is staged in two 32-bit load registers, one for the lower half and one for the upper half. Writing a load register never changes the running count by itself. The jump happens only when the top bit of the upper load register goes from 1 to 0. Software therefore writes the upper word once with its top bit set, and then again with that bit cleared. The value applied is the staged 64-bit word with bit 63 forced to zero.

The live count is read through two read-only indices. Reading the lower half also stores the upper half at that same edge. A later read of the upper half returns that stored copy, so the two halves always belong to one instant.

Top module: `ustime_core`

## Requirements
- R1: After reset, the count and both load registers are zero. Reads of index 2, 3, 58 and 59 then return 0.
- R2: A write to index 2 stores the lower load word and a write to index 3 stores the upper load word. A read of either index returns the last value written to it.
- R3: Writing only index 2 never changes the running count.
- R4: A write to index 3 with bit 31 clear, while the stored bit 31 is 1, reloads the count. The new value is {0, upper[30:0], lower[31:0]} and appears one clock edge after that write. A write to index 3 with bit 31 set causes no reload. A write with bit 31 clear while the stored bit 31 is already 0 also causes no reload.
- R5: In any cycle without a reload, the count rises by exactly one when the tick is high and holds when the tick is low.
- R6: When the lower 32 bits roll over from 0xFFFFFFFF, the carry goes into the upper 32 bits. The full 64-bit count wraps modulo 2^64.
- R7: A read of index 58 returns count[31:0] and stores count[63:32] at the same edge. A read of index 59 returns the most recently stored upper half. That copy is 0 after reset.
- R8: Writes to index 58 and 59 are ignored. The count and the load registers stay unchanged.
- R9: When a reload and a tick fall in the same cycle, the reload wins and that tick is dropped.
- R10: Read data is registered at the edge where the read strobe is sampled and holds until the next read. An index with no register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_idx | input | 6 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
A reload and a microsecond tick can land on the same clock edge. The bench provokes this by writing the upper load word with bit 31 cleared, then raising the tick only for the following cycle, which is the cycle in which the reload is applied. The result is judged by reading the count back: it must equal the loaded value exactly, and a later single tick must then add exactly one. A second overlap is also checked: a low-half read followed by a tick that carries into the upper half, where the upper-half read must still return the pre-carry word.

// File: rtl/ustime_pkg.sv
// Package: shared widths and register indices for the microsecond counter.
// Assumes one 32-bit register bus word; the count spans two bus words.
package ustime_pkg;
    localparam int WORD_W   = 32;
    localparam int IDX_W    = 6;
    localparam int CNT_W    = 2 * WORD_W;

    localparam logic [IDX_W-1:0] IDX_LOAD_LO = 6'd2;
    localparam logic [IDX_W-1:0] IDX_LOAD_HI = 6'd3;
    localparam logic [IDX_W-1:0] IDX_LIVE_LO = 6'd58;
    localparam logic [IDX_W-1:0] IDX_LIVE_HI = 6'd59;

    // Decoded bus access, one flag per register touched.
    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic rd_live_lo;
    } bus_dec_t;
endpackage

// File: rtl/ustime_loadregs.sv
// Module: staging registers for the reload value and the falling-edge
// detector on the top bit of the upper word.
// Assumes decoded write strobes; emits a one-cycle reload pulse in the
// cycle after the write that clears the top bit.
module ustime_loadregs
    import ustime_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_lo,
    input  logic           wr_hi,
    input  logic [W-1:0]   wdata,
    output logic [W-1:0]   load_lo,
    output logic [W-1:0]   load_hi,
    output logic           reload
);
    logic msb_prev;

    // Capture software writes into the staging registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_lo <= '0;
            load_hi <= '0;
        end else begin
            if (wr_lo) load_lo <= wdata;
            if (wr_hi) load_hi <= wdata;
        end
    end

    // Delay the top bit one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) msb_prev <= 1'b0;
        else        msb_prev <= load_hi[W-1];
    end

    // Reload on a 1-to-0 transition of the stored top bit.
    always_comb reload = msb_prev & ~load_hi[W-1];

    // R4: a reload pulse must follow a write of the upper word with top bit clear.
    a_r4_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        reload |-> $past(wr_hi && !wdata[W-1]));

    // R4: the pulse lasts one cycle only.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !reload);

    // R3: without an upper-word write the upper staging register holds.
    a_r3_hi_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(load_hi));
endmodule

// File: rtl/ustime_counter.sv
// Module: the 64-bit free-running microsecond count.
// Assumes reload and tick are synchronous to clk; reload has priority.
// The sum is split into lanes of one bus word each, chained by carry.
module ustime_counter
    import ustime_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload,
    input  logic [W*LANES-1:0] load_val,
    output logic [W*LANES-1:0] count
);
    localparam int CW = W * LANES;

    logic [CW-1:0]   count_inc;
    logic [LANES:0]  carry;

    assign carry[0] = 1'b1;

    // Per-lane increment with ripple carry between words.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [W:0] lane_sum;
        always_comb lane_sum = {1'b0, count[g*W +: W]} + {{W{1'b0}}, carry[g]};
        assign count_inc[g*W +: W] = lane_sum[W-1:0];
        assign carry[g+1]          = lane_sum[W];
    end

    // Apply reload first, else advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (reload) count <= load_val;
        else if (tick)   count <= count_inc;
    end

    // R4: count equals the staged value one edge after the reload pulse.
    a_r4_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> count == $past(load_val));

    // R9: tick alongside reload does not add one.
    a_r9_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && tick) |=> count == $past(load_val));

    // R5: one tick without reload adds exactly one (modulo 2^64, R6).
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload) |=> count == $past(count) + 1'b1);

    // R5: no tick and no reload keeps the count.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reload) |=> $stable(count));
endmodule

// File: rtl/ustime_readout.sv
// Module: registered read mux with a coherent copy of the upper half.
// Assumes a read of the lower live word precedes the upper live read.
module ustime_readout
    import ustime_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     load_lo,
    input  logic [W-1:0]     load_hi,
    input  logic [2*W-1:0]   count,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] hi_snap;
    logic [W-1:0] rd_mux;

    // Select the word addressed by the bus index.
    always_comb begin
        unique case (idx)
            IDX_LOAD_LO: rd_mux = load_lo;
            IDX_LOAD_HI: rd_mux = load_hi;
            IDX_LIVE_LO: rd_mux = count[W-1:0];
            IDX_LIVE_HI: rd_mux = hi_snap;
            default:     rd_mux = '0;
        endcase
    end

    // Register read data and take the upper-half copy on a lower read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata   <= '0;
            hi_snap <= '0;
        end else if (rd) begin
            rdata <= rd_mux;
            if (idx == IDX_LIVE_LO) hi_snap <= count[2*W-1:W];
        end
    end

    // R7: the copy tracks the upper half seen at the lower read.
    a_r7_snap_coherent: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && idx == IDX_LIVE_LO) |=> hi_snap == $past(count[2*W-1:W]));

    // R10: read data holds when no read is issued.
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/ustime_core.sv
// Module: top of the loadable microsecond timestamp counter.
// Assumes a single clock domain and a tick pulse of one cycle per microsecond.
module ustime_core
    import ustime_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_us,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [IW-1:0] bus_idx,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata
);
    localparam int LANES = 2;
    localparam int CW    = W * LANES;

    bus_dec_t       dec;
    logic [W-1:0]   load_lo;
    logic [W-1:0]   load_hi;
    logic           reload;
    logic [CW-1:0]  count;
    logic [CW-1:0]  load_val;

    // Decode bus strobes; live indices are read-only.
    always_comb begin
        dec.wr_lo      = bus_wr && (bus_idx == IDX_LOAD_LO);
        dec.wr_hi      = bus_wr && (bus_idx == IDX_LOAD_HI);
        dec.rd_live_lo = bus_rd && (bus_idx == IDX_LIVE_LO);
    end

    // Form the reload value with the trigger bit forced clear.
    always_comb load_val = {1'b0, load_hi[W-2:0], load_lo};

    ustime_loadregs #(.W(W)) u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (dec.wr_lo),
        .wr_hi   (dec.wr_hi),
        .wdata   (bus_wdata),
        .load_lo (load_lo),
        .load_hi (load_hi),
        .reload  (reload)
    );

    ustime_counter #(.W(W), .LANES(LANES)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_us),
        .reload   (reload),
        .load_val (load_val),
        .count    (count)
    );

    ustime_readout #(.W(W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .idx     (bus_idx),
        .load_lo (load_lo),
        .load_hi (load_hi),
        .count   (count),
        .rdata   (bus_rdata)
    );

    // R8: writes to live indices leave the staging registers untouched.
    a_r8_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_idx == IDX_LIVE_LO || bus_idx == IDX_LIVE_HI))
        |=> ($stable(load_lo) && $stable(load_hi)));

    // R3: a lower-word write alone never triggers a reload.
    a_r3_lo_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_idx == IDX_LOAD_LO) |=> !reload);
endmodule

// File: tb/ustime_core_tb.sv
module ustime_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ustime_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] idx, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_idx = idx;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_us = 1'b1;
            @(negedge clk); tick_us = 1'b0;
        end
    endtask

    // Stage a value and fire the 1-then-0 trigger; count loads next edge.
    task automatic load64(input logic [31:0] hi, input logic [31:0] lo);
        wr(6'd2, lo);
        wr(6'd3, hi | 32'h8000_0000);
        wr(6'd3, hi & 32'h7FFF_FFFF);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(6'd58, v); check("R1 live lo", v, 0);
        rd(6'd59, v); check("R1 live hi", v, 0);
        rd(6'd2, v);  check("R1 load lo", v, 0);
        rd(6'd3, v);  check("R1 load hi", v, 0);
    endtask

    task automatic t_store_and_lo_only;
        logic [31:0] v;
        wr(6'd2, 32'h1234_5678);
        rd(6'd2, v);  check("R2 load lo readback", v, 32'h1234_5678);
        rd(6'd58, v); check("R3 lo write no reload", v, 0);
        wr(6'd3, 32'h8000_0055);
        rd(6'd3, v);  check("R2 load hi readback", v, 32'h8000_0055);
        rd(6'd58, v); check("R4 msb set no reload", v, 0);
    endtask

    task automatic t_reload;
        logic [31:0] v;
        wr(6'd3, 32'h0000_0055);
        @(negedge clk);
        rd(6'd58, v); check("R4 reload lo", v, 32'h1234_5678);
        rd(6'd59, v); check("R4 reload hi", v, 32'h0000_0055);
        wr(6'd3, 32'h0000_0077);
        @(negedge clk);
        rd(6'd58, v); rd(6'd59, v);
        check("R4 msb already clear no reload", v, 32'h0000_0055);
    endtask

    task automatic t_tick;
        logic [31:0] v;
        ticks(5);
        repeat (3) @(negedge clk);
        rd(6'd58, v); check("R5 five ticks", v, 32'h1234_567D);
    endtask

    task automatic t_carry;
        logic [31:0] v;
        load64(32'h0000_0010, 32'hFFFF_FFFE);
        ticks(3);
        rd(6'd58, v); check("R6 carry lo", v, 32'h0000_0001);
        rd(6'd59, v); check("R6 carry hi", v, 32'h0000_0011);
    endtask

    task automatic t_coherent;
        logic [31:0] v;
        load64(32'h0000_0020, 32'hFFFF_FFFF);
        rd(6'd58, v); check("R7 lo before carry", v, 32'hFFFF_FFFF);
        ticks(1);
        rd(6'd59, v); check("R7 hi coherent copy", v, 32'h0000_0020);
        rd(6'd58, v); check("R7 lo after carry", v, 0);
        rd(6'd59, v); check("R7 hi new copy", v, 32'h0000_0021);
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        wr(6'd58, 32'hDEAD_BEEF);
        wr(6'd59, 32'hCAFE_F00D);
        rd(6'd58, v); check("R8 live lo unchanged", v, 0);
        rd(6'd59, v); check("R8 live hi unchanged", v, 32'h0000_0021);
        rd(6'd2, v);  check("R8 load lo unchanged", v, 32'hFFFF_FFFF);
        rd(6'd3, v);  check("R8 load hi unchanged", v, 32'h0000_0020);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(6'd2, 32'h0000_0100);
        wr(6'd3, 32'h8000_0000);
        @(negedge clk);
        bus_wr = 1'b1; bus_idx = 6'd3; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0; tick_us = 1'b1;   // reload applied at this next edge
        @(negedge clk);
        tick_us = 1'b0;
        rd(6'd58, v); check("R9 reload wins over tick", v, 32'h0000_0100);
        rd(6'd59, v); check("R9 hi after collide", v, 0);
        ticks(1);
        rd(6'd58, v); check("R9 next tick counts", v, 32'h0000_0101);
    endtask

    task automatic t_misc;
        logic [31:0] v;
        rd(6'd7, v); check("R10 unmapped index", v, 0);
        rd(6'd2, v);
        repeat (4) @(negedge clk);
        check("R10 rdata holds", bus_rdata, 32'h0000_0100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_store_and_lo_only();
        t_reload();
        t_tick();
        t_carry();
        t_coherent();
        t_readonly();
        t_collide();
        t_misc();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule